// File: doc/BRIEF.md
# Card Data FIFO Transfer Engine

This block carries the data phase of a memory-card transfer between a processor register port and a byte-wide card data stream. It holds one byte queue per direction, each 32 bytes deep, and a down-counter of bytes still owed for the transfer. A start pulse loads the counter with the product of a block count and a block length, and picks the direction. On a write, the engine hands bytes from the transmit queue to the card stream. On a read, it takes bytes from the card stream into the receive queue.

The processor moves 1, 2 or 4 bytes per access. The first byte in queue order always sits in the most significant byte of the accessed group. Two sticky service requests tell the processor when the transmit queue has run dry with bytes still owed, and when received bytes are waiting. One-cycle pulses and two sticky status bits mark the end of the transfer. A partial-buffer command throws away what is in the transmit queue and moves it to the other half of its storage. An abort input stops the transfer and leaves both queues as they are.

Top module: `card_fifo_engine`

## Requirements
- R1: After reset, `xfer_active`, `card_tx_valid`, `card_rx_ready`, `tx_req`, `rx_req`, `done_pulse` and `prog_pulse` are 0, `xfer_stat` is 0, and `cpu_rdata` is 0.
- R2: A `xfer_start` pulse loads the byte counter with `blk_cnt * blk_len`. `xfer_write` = 1 selects card writes and 0 selects card reads. Exactly that many bytes cross the card stream, and only the selected direction is ever offered.
- R3: During a write, `card_tx_valid` is high while the transmit queue is not empty. Bytes leave in queue order and hold steady while the card stalls. `tx_req` is set in the cycle after the queue runs empty with bytes still owed (including right after a write start). Any processor write clears it.
- R4: During a read, `card_rx_ready` is high while the receive queue holds fewer than 32 bytes. Each accepted byte sets `rx_req`, and a processor read clears it.
- R5: `cpu_size` 0, 1 and 2 select 1, 2 and 4 bytes. For an access of N bytes, the first queue byte maps to `data[8N-1:8N-8]` and later bytes map to lower lanes.
- R6: A processor write stops once the transmit queue holds 32 bytes. The bytes that do not fit are dropped.
- R7: A processor read stops once the receive queue is empty. Lanes that were not filled, and all bits above bit 8N-1, read as 0.
- R8: When the last owed byte moves, `xfer_active` falls and `done_pulse` is high for one cycle. Status bit 11 of `xfer_stat` is then set. For a write, `prog_pulse` also pulses and status bit 12 is set. A start with a product of zero completes in the cycle that follows.
- R9: A `tx_flush` pulse empties the transmit queue. The next bytes written are the next bytes sent.
- R10: `xfer_abort` drops `xfer_active` on the next cycle. It does not signal completion and keeps the queued bytes readable.
- R11: `xfer_start` empties both queues and clears status bits 11 and 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | Start pulse for a data transfer |
| xfer_write | input | 1 | Direction at start: 1 write to card, 0 read from card |
| blk_len | input | 12 | Bytes per block |
| blk_cnt | input | 16 | Number of blocks |
| xfer_abort | input | 1 | Stops the transfer at once |
| cpu_wr | input | 1 | Processor write into the transmit queue |
| cpu_rd | input | 1 | Processor read from the receive queue |
| cpu_size | input | 2 | Access size code: 0 one byte, 1 two bytes, 2 four bytes |
| cpu_wdata | input | 32 | Write data, first byte most significant |
| cpu_rdata | output | 32 | Read data for the current access |
| tx_flush | input | 1 | Partial-buffer command: empty the transmit queue and switch its half |
| card_tx_data | output | 8 | Byte to the card |
| card_tx_valid | output | 1 | Byte to the card is valid |
| card_tx_ready | input | 1 | Card takes the byte |
| card_rx_data | input | 8 | Byte from the card |
| card_rx_valid | input | 1 | Byte from the card is valid |
| card_rx_ready | output | 1 | Engine takes the byte |
| xfer_active | output | 1 | Transfer in progress |
| tx_req | output | 1 | Transmit service request |
| rx_req | output | 1 | Receive service request |
| done_pulse | output | 1 | One-cycle data-done event |
| prog_pulse | output | 1 | One-cycle programming-done event (writes) |
| xfer_stat | output | 16 | Status word: bit 11 data done, bit 12 programming done |

## Verification
The bench uses the default parameters: 32-byte queues, a 4-byte processor port, and 12-bit and 16-bit length fields. With these values, filling a queue to its limit takes only a few dozen cycles. The bench can therefore drive the full-queue write drop, the receive-side stall at 32 bytes, and a 64-byte write that uses both halves of the transmit store through a flush, all well inside the run. The 4-byte port is also wide enough to show all three access sizes and partial reads that leave low lanes empty.

// File: rtl/cfe_pkg.sv
package cfe_pkg;

    localparam int STAT_DATA_DONE_BIT = 11;
    localparam int STAT_PROG_DONE_BIT = 12;

    // Access size code to byte count, capped at the port width.
    function automatic int unsigned access_bytes(input logic [1:0] code, input int unsigned lanes);
        int unsigned n;
        n = 1 << code;
        if (n > lanes) n = lanes;
        return n;
    endfunction

endpackage

// File: rtl/cfe_byte_queue.sv
module cfe_byte_queue #(
    parameter int DEPTH  = 32,
    parameter int HALVES = 1,
    parameter int LANES  = 4,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int NW    = $clog2(LANES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               flip,
    input  logic [NW-1:0]      push_n,
    input  logic [LANES*8-1:0] push_lanes,
    input  logic [NW-1:0]      pop_n,
    output logic [LANES*8-1:0] pop_lanes,
    output logic [7:0]         head_byte,
    output logic [CW-1:0]      count,
    output logic [CW-1:0]      count_nx
);

    localparam int AW    = $clog2(DEPTH);
    localparam int SLOTS = DEPTH * HALVES;
    localparam int SW    = $clog2(SLOTS);

    typedef struct packed {
        logic [SLOTS-1:0][7:0] mem;
        logic [AW-1:0]         head;
        logic [CW-1:0]         cnt;
    } q_state_t;

    q_state_t st_d, st_q;
    logic half;
    logic [CW-1:0] free_c, push_acc, pop_acc;

    function automatic logic [SW-1:0] slot_of(input logic [AW-1:0] p, input logic h);
        return SW'(p) + (h ? SW'(DEPTH) : SW'(0));
    endfunction

    generate
        if (HALVES > 1) begin : g_split
            logic half_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    half_q <= 1'b0;
                else if (flip) half_q <= ~half_q;
            end
            assign half = half_q;
        end else begin : g_flat
            assign half = 1'b0;
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        free_c    = CW'(DEPTH) - st_q.cnt;
        push_acc  = (CW'(push_n) < free_c) ? CW'(push_n) : free_c;
        pop_acc   = (CW'(pop_n) < st_q.cnt) ? CW'(pop_n) : st_q.cnt;
        pop_lanes = '0;
        for (int i = 0; i < LANES; i++) begin
            if (CW'(i) < pop_acc)
                pop_lanes[8*i +: 8] = st_q.mem[slot_of(st_q.head + AW'(i), half)];
        end
        if (clear || flip) begin
            st_d.cnt = '0;
        end else begin
            for (int i = 0; i < LANES; i++) begin
                if (CW'(i) < push_acc)
                    st_d.mem[slot_of(st_q.head + AW'(st_q.cnt) + AW'(i), half)] = push_lanes[8*i +: 8];
            end
            st_d.head = st_q.head + AW'(pop_acc);
            st_d.cnt  = st_q.cnt + push_acc - pop_acc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_byte = st_q.mem[slot_of(st_q.head, half)];
    assign count     = st_q.cnt;
    assign count_nx  = st_d.cnt;

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // R9 R11
    empty_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear || flip) |=> (st_q.cnt == '0));

endmodule

// File: rtl/cfe_xfer_ctrl.sv
module cfe_xfer_ctrl #(
    parameter int LEN_W = 12,
    parameter int CNT_W = 16,
    parameter int CW    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dir_wr,
    input  logic [LEN_W-1:0] blk_len,
    input  logic [CNT_W-1:0] blk_cnt,
    input  logic             abort,
    input  logic             tx_beat,
    input  logic             rx_beat,
    input  logic             tx_wr,
    input  logic             rx_rd,
    input  logic [CW-1:0]    tx_cnt_nx,
    output logic             active,
    output logic             wr,
    output logic             tx_req,
    output logic             rx_req,
    output logic             done_p,
    output logic             prog_p,
    output logic             stat_done,
    output logic             stat_prog
);

    localparam int LW = LEN_W + CNT_W;

    typedef struct packed {
        logic          active;
        logic          wr;
        logic [LW-1:0] left;
        logic          tx_req;
        logic          rx_req;
        logic          done_p;
        logic          prog_p;
        logic          stat_done;
        logic          stat_prog;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic          beat;
    logic [LW-1:0] left_n, total;

    always_comb begin
        st_d        = st_q;
        st_d.done_p = 1'b0;
        st_d.prog_p = 1'b0;
        beat   = st_q.wr ? tx_beat : rx_beat;
        left_n = st_q.left - LW'(beat);
        total  = LW'(blk_cnt) * LW'(blk_len);
        if (tx_wr) st_d.tx_req = 1'b0;
        if (rx_rd) st_d.rx_req = 1'b0;
        if (start) begin
            st_d.wr        = dir_wr;
            st_d.left      = total;
            st_d.stat_done = 1'b0;
            st_d.stat_prog = 1'b0;
            st_d.rx_req    = 1'b0;
            if (total == '0) begin
                st_d.active    = 1'b0;
                st_d.tx_req    = 1'b0;
                st_d.done_p    = 1'b1;
                st_d.stat_done = 1'b1;
                st_d.prog_p    = dir_wr;
                st_d.stat_prog = dir_wr;
            end else begin
                st_d.active = 1'b1;
                st_d.tx_req = dir_wr;
            end
        end else if (st_q.active) begin
            st_d.left = left_n;
            if (rx_beat) st_d.rx_req = 1'b1;
            if (left_n == '0) begin
                st_d.active    = 1'b0;
                st_d.done_p    = 1'b1;
                st_d.stat_done = 1'b1;
                st_d.prog_p    = st_q.wr;
                st_d.stat_prog = st_q.stat_prog | st_q.wr;
            end else if (st_q.wr && tx_cnt_nx == '0) begin
                st_d.tx_req = 1'b1;
            end
        end
        if (abort) st_d.active = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active    = st_q.active;
    assign wr        = st_q.wr;
    assign tx_req    = st_q.tx_req;
    assign rx_req    = st_q.rx_req;
    assign done_p    = st_q.done_p;
    assign prog_p    = st_q.prog_p;
    assign stat_done = st_q.stat_done;
    assign stat_prog = st_q.stat_prog;

    // R8
    done_clears_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done_p |-> !st_q.active);

    // R8
    prog_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.prog_p |-> st_q.done_p);

    // R10
    abort_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !st_q.active);

    // R4
    rx_req_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_beat && !start) |=> st_q.rx_req);

endmodule

// File: rtl/card_fifo_engine.sv
module card_fifo_engine #(
    parameter int DEPTH  = 32,
    parameter int LANES  = 4,
    parameter int LEN_W  = 12,
    parameter int CNT_W  = 16,
    parameter int STAT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               xfer_start,
    input  logic               xfer_write,
    input  logic [LEN_W-1:0]   blk_len,
    input  logic [CNT_W-1:0]   blk_cnt,
    input  logic               xfer_abort,
    input  logic               cpu_wr,
    input  logic               cpu_rd,
    input  logic [1:0]         cpu_size,
    input  logic [LANES*8-1:0] cpu_wdata,
    output logic [LANES*8-1:0] cpu_rdata,
    input  logic               tx_flush,
    output logic [7:0]         card_tx_data,
    output logic               card_tx_valid,
    input  logic               card_tx_ready,
    input  logic [7:0]         card_rx_data,
    input  logic               card_rx_valid,
    output logic               card_rx_ready,
    output logic               xfer_active,
    output logic               tx_req,
    output logic               rx_req,
    output logic               done_pulse,
    output logic               prog_pulse,
    output logic [STAT_W-1:0]  xfer_stat
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int NW = $clog2(LANES + 1);

    logic [NW-1:0]      nb;
    logic [LANES*8-1:0] tx_push_lanes, rx_push_lanes, rx_pop_lanes;
    logic [LANES*8-1:0] tx_pop_unused;
    logic [7:0]         rx_head_unused;
    logic [CW-1:0]      tx_cnt, tx_cnt_nx, rx_cnt, rx_cnt_nx_unused;
    logic               tx_beat, rx_beat, xfer_wr, stat_done, stat_prog;

    assign nb = NW'(cfe_pkg::access_bytes(cpu_size, LANES));

    // First queue byte lives in the most significant byte of the access.
    always_comb begin
        tx_push_lanes = '0;
        cpu_rdata     = '0;
        for (int i = 0; i < LANES; i++) begin
            if (i < int'(nb)) begin
                tx_push_lanes[8*i +: 8]                   = cpu_wdata[8*(int'(nb)-1-i) +: 8];
                cpu_rdata[8*(int'(nb)-1-i) +: 8]          = rx_pop_lanes[8*i +: 8];
            end
        end
    end

    assign rx_push_lanes = {{(LANES-1)*8{1'b0}}, card_rx_data};

    assign card_tx_valid = xfer_active && xfer_wr && (tx_cnt != '0);
    assign card_rx_ready = xfer_active && !xfer_wr && (rx_cnt != CW'(DEPTH));
    assign tx_beat       = card_tx_valid && card_tx_ready;
    assign rx_beat       = card_rx_valid && card_rx_ready;

    cfe_byte_queue #(.DEPTH(DEPTH), .HALVES(2), .LANES(LANES)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (xfer_start),
        .flip      (tx_flush),
        .push_n    (cpu_wr ? nb : NW'(0)),
        .push_lanes(tx_push_lanes),
        .pop_n     (NW'(tx_beat)),
        .pop_lanes (tx_pop_unused),
        .head_byte (card_tx_data),
        .count     (tx_cnt),
        .count_nx  (tx_cnt_nx)
    );

    cfe_byte_queue #(.DEPTH(DEPTH), .HALVES(1), .LANES(LANES)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (xfer_start),
        .flip      (1'b0),
        .push_n    (NW'(rx_beat)),
        .push_lanes(rx_push_lanes),
        .pop_n     (cpu_rd ? nb : NW'(0)),
        .pop_lanes (rx_pop_lanes),
        .head_byte (rx_head_unused),
        .count     (rx_cnt),
        .count_nx  (rx_cnt_nx_unused)
    );

    cfe_xfer_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W), .CW(CW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (xfer_start),
        .dir_wr   (xfer_write),
        .blk_len  (blk_len),
        .blk_cnt  (blk_cnt),
        .abort    (xfer_abort),
        .tx_beat  (tx_beat),
        .rx_beat  (rx_beat),
        .tx_wr    (cpu_wr),
        .rx_rd    (cpu_rd),
        .tx_cnt_nx(tx_cnt_nx),
        .active   (xfer_active),
        .wr       (xfer_wr),
        .tx_req   (tx_req),
        .rx_req   (rx_req),
        .done_p   (done_pulse),
        .prog_p   (prog_pulse),
        .stat_done(stat_done),
        .stat_prog(stat_prog)
    );

    always_comb begin
        xfer_stat = '0;
        xfer_stat[cfe_pkg::STAT_DATA_DONE_BIT] = stat_done;
        xfer_stat[cfe_pkg::STAT_PROG_DONE_BIT] = stat_prog;
    end

    // R3
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (card_tx_valid && !card_tx_ready && !tx_flush && !xfer_abort && !xfer_start)
        |=> (card_tx_valid && $stable(card_tx_data)));

    // R2
    one_direction_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(card_tx_valid && card_rx_ready));

endmodule

// File: tb/card_fifo_engine_tb.sv
`timescale 1ns/1ps
module card_fifo_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start = 1'b0, xfer_write = 1'b0, xfer_abort = 1'b0;
    logic [11:0] blk_len = '0;
    logic [15:0] blk_cnt = '0;
    logic        cpu_wr = 1'b0, cpu_rd = 1'b0, tx_flush = 1'b0;
    logic [1:0]  cpu_size = '0;
    logic [31:0] cpu_wdata = '0, cpu_rdata;
    logic [7:0]  card_tx_data, card_rx_data = '0;
    logic        card_tx_valid, card_tx_ready = 1'b0;
    logic        card_rx_valid = 1'b0, card_rx_ready;
    logic        xfer_active, tx_req, rx_req, done_pulse, prog_pulse;
    logic [15:0] xfer_stat;

    int checks = 0, errors = 0;
    int tx_sent = 0, done_cnt = 0, prog_cnt = 0;
    logic [7:0] sb_q[$];
    logic [7:0] rx_arr[64];
    int rx_n = 0, rx_idx = 0;
    logic rx_hs = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    card_fifo_engine dut_i (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_write(xfer_write),
        .blk_len(blk_len), .blk_cnt(blk_cnt), .xfer_abort(xfer_abort),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .tx_flush(tx_flush),
        .card_tx_data(card_tx_data), .card_tx_valid(card_tx_valid), .card_tx_ready(card_tx_ready),
        .card_rx_data(card_rx_data), .card_rx_valid(card_rx_valid), .card_rx_ready(card_rx_ready),
        .xfer_active(xfer_active), .tx_req(tx_req), .rx_req(rx_req),
        .done_pulse(done_pulse), .prog_pulse(prog_pulse), .xfer_stat(xfer_stat)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: card transmit bytes against the scoreboard, event counters.
    always @(negedge clk) begin
        #1;
        if (rst_n && card_tx_valid && card_tx_ready) begin
            tx_sent++;
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL R3 actual=%h expected=none (unexpected card byte)", card_tx_data);
            end else begin
                logic [7:0] e;
                e = sb_q.pop_front();
                if (card_tx_data !== e) begin
                    errors++;
                    $display("FAIL R3 actual=%h expected=%h (card byte order)", card_tx_data, e);
                end
            end
        end
        if (rst_n && done_pulse) done_cnt++;
        if (rst_n && prog_pulse) prog_cnt++;
    end

    // Card source for the receive stream.
    always @(negedge clk) begin
        if (rx_hs) rx_idx++;
        card_rx_valid = (rx_idx < rx_n);
        card_rx_data  = rx_arr[rx_idx % 64];
        rx_hs         = card_rx_valid && card_rx_ready;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu_write(input logic [1:0] sz, input logic [31:0] d, input bit push);
        int n;
        n = 1 << sz;
        @(negedge clk);
        cpu_wr = 1'b1; cpu_size = sz; cpu_wdata = d;
        if (push) for (int i = n - 1; i >= 0; i--) sb_q.push_back(d[8*i +: 8]);
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] sz, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_size = sz;
        #1 check(tag, cpu_rdata, exp);
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic start_xfer(input bit w, input logic [11:0] len, input logic [15:0] cnt);
        @(negedge clk);
        xfer_write = w; blk_len = len; blk_cnt = cnt; xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
    endtask

    task automatic wait_done(input int base);
        for (int k = 0; k < 200 && done_cnt == base; k++) @(negedge clk);
        #2;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int d0, p0, s0;
        cyc(3);
        #1;
        // R1 reset state
        check("R1 active", xfer_active, 0);
        check("R1 tx_valid", card_tx_valid, 0);
        check("R1 rx_ready", card_rx_ready, 0);
        check("R1 reqs", {tx_req, rx_req, done_pulse, prog_pulse}, 0);
        check("R1 stat", xfer_stat, 0);
        check("R1 rdata", cpu_rdata, 0);
        @(negedge clk); rst_n = 1'b1;
        cyc(2);

        // Write of 2 blocks x 3 bytes (R2 R3 R5 R8)
        card_tx_ready = 1'b1;
        d0 = done_cnt; p0 = prog_cnt; s0 = tx_sent;
        start_xfer(1'b1, 12'd3, 16'd2);
        #2;
        check("R3 tx_req after write start", tx_req, 1);
        check("R2 active", xfer_active, 1);
        check("R2 no rx in write", card_rx_ready, 0);
        cpu_write(2'd2, 32'hA1B2C3D4, 1'b1);
        cyc(7);
        #2;
        check("R3 tx_req when drained", tx_req, 1);
        check("R3 four bytes sent", tx_sent - s0, 4);
        cpu_write(2'd1, 32'h0000E5F6, 1'b1);
        #2;
        check("R3 tx_req cleared by write", tx_req, 0);
        wait_done(d0);
        check("R2 byte total", tx_sent - s0, 6);
        check("R8 done pulse", done_cnt - d0, 1);
        check("R8 prog pulse", prog_cnt - p0, 1);
        check("R8 stat write", xfer_stat, 32'h1800);
        check("R8 inactive", xfer_active, 0);
        check("R3 scoreboard empty", sb_q.size(), 0);

        // Read of 5 bytes (R2 R4 R5 R7 R8)
        d0 = done_cnt; p0 = prog_cnt;
        rx_arr[0] = 8'h10; rx_arr[1] = 8'h21; rx_arr[2] = 8'h32; rx_arr[3] = 8'h43; rx_arr[4] = 8'h54;
        @(negedge clk); rx_idx = 0; rx_n = 5;
        start_xfer(1'b0, 12'd5, 16'd1);
        #2;
        check("R2 no tx in read", card_tx_valid, 0);
        wait_done(d0);
        check("R4 rx_req set", rx_req, 1);
        check("R8 read stat", xfer_stat, 32'h0800);
        check("R8 no prog on read", prog_cnt - p0, 0);
        cpu_read(2'd1, 32'h00001021, "R5 two-byte read");
        #2;
        check("R4 rx_req cleared", rx_req, 0);
        cpu_read(2'd2, 32'h32435400, "R7 short four-byte read");
        cpu_read(2'd0, 32'h00000000, "R7 empty read");

        // 64-byte write: queue limit, flush, abort (R6 R9 R10 R3)
        card_tx_ready = 1'b0;
        d0 = done_cnt;
        start_xfer(1'b1, 12'd64, 16'd1);
        for (int k = 0; k < 8; k++) cpu_write(2'd2, {8'(4*k), 8'(4*k+1), 8'(4*k+2), 8'(4*k+3)}, 1'b1);
        cpu_write(2'd2, 32'hDEADBEEF, 1'b0);
        s0 = tx_sent;
        @(negedge clk); card_tx_ready = 1'b1;
        cyc(40);
        #2;
        check("R6 only 32 bytes sent", tx_sent - s0, 32);
        check("R3 tx_req on empty", tx_req, 1);
        @(negedge clk); card_tx_ready = 1'b0;
        cpu_write(2'd2, 32'h01020304, 1'b0);
        @(negedge clk); tx_flush = 1'b1;
        @(negedge clk); tx_flush = 1'b0;
        cpu_write(2'd1, 32'h00007788, 1'b1);
        s0 = tx_sent;
        @(negedge clk); card_tx_ready = 1'b1;
        cyc(6);
        #2;
        check("R9 bytes after flush", tx_sent - s0, 2);
        check("R9 scoreboard empty", sb_q.size(), 0);
        @(negedge clk); xfer_abort = 1'b1;
        @(negedge clk); xfer_abort = 1'b0;
        #2;
        check("R10 abort inactive", xfer_active, 0);
        check("R10 tx stops", card_tx_valid, 0);
        check("R10 no done", done_cnt - d0, 0);

        // Zero-length write (R8)
        d0 = done_cnt; p0 = prog_cnt;
        start_xfer(1'b1, 12'd7, 16'd0);
        #2;
        check("R8 zero-length done", done_cnt - d0, 1);
        check("R8 zero-length prog", prog_cnt - p0, 1);
        check("R8 zero-length stat", xfer_stat, 32'h1800);
        check("R8 zero-length inactive", xfer_active, 0);

        // Start clears status and queues (R11)
        card_tx_ready = 1'b0;
        start_xfer(1'b1, 12'd4, 16'd1);
        #2;
        check("R11 stat cleared", xfer_stat, 0);
        cpu_write(2'd1, 32'h0000AAAA, 1'b0);
        d0 = done_cnt;
        start_xfer(1'b1, 12'd4, 16'd1);
        #2;
        check("R11 tx queue emptied", card_tx_valid, 0);
        check("R3 tx_req on restart", tx_req, 1);
        cpu_write(2'd2, 32'h11223344, 1'b1);
        @(negedge clk); card_tx_ready = 1'b1;
        wait_done(d0);
        check("R11 restart completes", done_cnt - d0, 1);
        check("R11 scoreboard empty", sb_q.size(), 0);

        // Receive stall at 32, then abort keeps bytes (R4 R10)
        d0 = done_cnt;
        for (int k = 0; k < 40; k++) rx_arr[k] = 8'(8'h80 + k);
        @(negedge clk); rx_idx = 0; rx_n = 40;
        start_xfer(1'b0, 12'd40, 16'd1);
        cyc(45);
        #2;
        check("R4 fill stops at 32", rx_idx, 32);
        check("R4 rx_ready low when full", card_rx_ready, 0);
        check("R4 still active", xfer_active, 1);
        @(negedge clk); xfer_abort = 1'b1;
        @(negedge clk); xfer_abort = 1'b0;
        #2;
        check("R10 abort read inactive", xfer_active, 0);
        check("R10 abort no done", done_cnt - d0, 0);
        cpu_read(2'd2, 32'h80818283, "R10 bytes kept after abort");
        @(negedge clk); rx_n = 0;

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule